// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Random Read

This block is the slave end of a two-wire (I2C) serial EEPROM with its own internal byte array. SCL and SDA from the pads are passed through a synchroniser into the system clock domain. Start, repeated Start and Stop are detected there, and the bus is decoded by a bit-level state machine. SDA is driven open-drain. The block asserts `sda_oe` to pull the line low and leaves it clear to let the line float high.

A host stores a byte by sending a write device byte, a word address byte, one data byte and a Stop. To read from any location, the host sends a write device byte and a word address, then issues a repeated Start instead of a data byte. This "dummy write" only loads the address. The host then sends a read device byte, and the slave shifts out bytes until the host refuses one. The parameter `MEM_BYTES` (128, 256, 512 or 1024) sets which device byte bits are compared with the chip select pins and which extend the word address.

The bus pins carry no data stream with a valid/ready handshake. The host paces every transfer by clocking SCL, so `chip_sel` and the bus pins are plain levels and there is no back-pressure.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A Start or repeated Start is SDA falling while SCL is high. It begins a new device byte from any state. A Stop is SDA rising while SCL is high, and it ends the transaction.
- R2: The device byte has the fixed code 4'b1010 in bits 7:4 and R/W in bit 0. The slave pulls SDA low on the ninth clock only when the code and every chip select bit match. Otherwise it stays released until the next Start or Stop.
- R3: For 128 and 256 bytes, device bits 3:1 are compared with chip_sel[2:0], and bit 7 of the word address byte is ignored at 128 bytes. For 512 bytes, bits 3:2 are compared with chip_sel[2:1] and bit 1 is word address bit 8. For 1024 bytes, bit 3 is compared with chip_sel[2], and bits 2:1 are word address bits 9:8.
- R4: After a matching write device byte, the word address byte is acknowledged and loads the internal address.
- R5: A write cut off by a repeated Start after the word address writes nothing. It leaves the loaded address in place.
- R6: After a matching read device byte is acknowledged, the byte at the current address is shifted out MSB first. On a read, the device byte bits that carry upper address bits on a write are ignored.
- R7: The address increments after every byte read and wraps from MEM_BYTES-1 to 0. When the host acknowledges a byte, the next byte follows.
- R8: A host NACK on the ninth clock of a read byte ends the read. SDA stays released until a Start or Stop.
- R9: A data byte is acknowledged. It is stored at the loaded address only when a Stop follows, and the address then increments. A Start before the Stop discards the data. A second data byte is not acknowledged.
- R10: The slave changes SDA only while SCL is low.
- R11: After reset SDA is released, the address is 0 and every byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel | input | 3 | Strapped chip select levels compared with device byte bits 3:1 |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad (wired-AND bus) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench uses the 512-byte size. It aims at a dummy write whose read device byte carries the opposite bit 1. A design that takes bit 1 from the read byte would return the byte from the other half of the array. A sequential read that starts at the top address must continue at address 0; a design that does not wrap would return the wrong byte or stall. A data byte followed by a repeated Start must leave memory unchanged, while a write followed by a Stop must store the byte and advance the address. A design that writes early, or does not advance, returns the wrong value on the following current-address read. The bench also sends a chip select mismatch, a wrong device code, and clocks after a host NACK, and it checks that SDA stays released in each case.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WORD, ST_WORD_ACK,
    ST_DATA, ST_DATA_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } ee_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2c_ee_line_sync.sv
module i2c_ee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

  // R9: a committed byte is readable at its address on the next cycle
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> cells[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter int MEM_BYTES   = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] chip_sel,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int HW = (AW > 8) ? AW - 8 : 1;
  localparam logic [2:0] CS_MASK = (AW <= 8) ? 3'b111 : (AW == 9) ? 3'b110 : 3'b100;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ee_state_e       state;
  logic [3:0]      cnt;
  logic [7:0]      sh;
  logic            dev_rw;
  logic [HW-1:0]   dev_hi;
  logic [AW-1:0]   addr;
  logic [AW-1:0]   wa_next;
  logic [7:0]      wdat;
  logic            wr_pend;
  logic            host_ack;
  logic            oe;
  logic [7:0]      rd_byte;
  logic            mem_we;
  logic            dev_match;

  assign dev_match = (sh[7:4] == DEV_CODE) && (((sh[3:1] ^ chip_sel) & CS_MASK) == 3'b000);
  assign mem_we    = stop_det & wr_pend;

  generate
    if (AW > 8) begin : g_hi_addr
      assign wa_next = {dev_hi, sh};
    end else begin : g_lo_addr
      assign wa_next = sh[AW-1:0];
    end
  endgenerate

  i2c_ee_mem #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(addr), .wdata(wdat),
    .raddr(addr), .rdata(rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      dev_rw   <= 1'b0;
      dev_hi   <= '0;
      addr     <= '0;
      wdat     <= '0;
      wr_pend  <= 1'b0;
      host_ack <= 1'b0;
      oe       <= 1'b0;
    end else if (start_det) begin
      state   <= ST_DEV;
      cnt     <= '0;
      wr_pend <= 1'b0;
      oe      <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      oe      <= 1'b0;
      wr_pend <= 1'b0;
      if (wr_pend) addr <= addr + 1'b1;
    end else begin
      case (state)
        ST_DEV, ST_WORD, ST_DATA: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (state == ST_DEV) begin
              if (dev_match) begin
                dev_rw <= sh[0];
                dev_hi <= sh[HW:1];
                oe     <= 1'b1;
                state  <= ST_DEV_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end else if (state == ST_WORD) begin
              addr  <= wa_next;
              oe    <= 1'b1;
              state <= ST_WORD_ACK;
            end else begin
              wdat    <= sh;
              wr_pend <= 1'b1;
              oe      <= 1'b1;
              state   <= ST_DATA_ACK;
            end
          end
        end
        ST_DEV_ACK: if (scl_fall) begin
          cnt <= '0;
          if (dev_rw) begin
            sh    <= rd_byte;
            oe    <= ~rd_byte[7];
            state <= ST_RD;
          end else begin
            oe    <= 1'b0;
            state <= ST_WORD;
          end
        end
        ST_WORD_ACK: if (scl_fall) begin
          oe    <= 1'b0;
          cnt   <= '0;
          state <= ST_DATA;
        end
        ST_DATA_ACK: if (scl_fall) begin
          oe    <= 1'b0;
          state <= ST_SKIP;
        end
        ST_RD: if (scl_fall) begin
          if (cnt == 4'd7) begin
            oe    <= 1'b0;
            addr  <= addr + 1'b1;
            state <= ST_RD_ACK;
          end else begin
            cnt <= cnt + 1'b1;
            sh  <= {sh[6:0], 1'b0};
            oe  <= ~sh[6];
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) host_ack <= ~sda_s;
          else if (scl_fall) begin
            if (host_ack) begin
              sh    <= rd_byte;
              oe    <= ~rd_byte[7];
              cnt   <= '0;
              state <= ST_RD;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe;

  // R10: SDA drive changes only with SCL low
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R7: each finished read byte advances the address, wrapping at the top
  a_r7_read_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD && scl_fall && cnt == 4'd7 && !start_det && !stop_det)
      |=> addr == AW'($past(addr) + 1'b1));

  // R9: a committed write advances the address
  a_r9_commit_advances: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> addr == AW'($past(addr) + 1'b1));

  // R5: memory is written only after an acknowledged data byte
  a_r5_write_only_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> state == ST_SKIP);

  // R8: the slave never drives SDA while ignoring the bus
  a_r8_skip_released: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SKIP |-> !sda_oe);

  // R2: the device byte acknowledge holds SDA low
  a_r2_ack_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DEV_ACK |-> sda_oe);
endmodule

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [2:0] cs_pins = 3'b101;

  int checks = 0;
  int fails = 0;
  int r10_bad = 0;

  byte unsigned exp_q[$];
  byte unsigned got_q[$];
  string        tag_q[$];
  event         got_ev;

  always #2.5 clk = ~clk;

  assign sda_line = sda_h & ~sda_oe;

  i2c_eeprom_slave #(.MEM_BYTES(512)) dut (
    .clk(clk), .rst_n(rst_n), .chip_sel(cs_pins),
    .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; hold(H);
    scl = 1'b1;   hold(H);
    sda_h = 1'b0; hold(H);
    scl = 1'b0;   hold(H);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; hold(H);
    scl = 1'b1;   hold(H);
    sda_h = 1'b1; hold(H);
  endtask

  task automatic send_byte(input byte unsigned b, input bit exp_ack, input string req);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; hold(H);
      scl = 1'b1;   hold(H);
      scl = 1'b0;
    end
    sda_h = 1'b1; hold(H);
    scl = 1'b1;   hold(H / 2);
    ack = ~sda_line;
    hold(H / 2);
    scl = 1'b0;
    chk(ack == exp_ack, req, ack, exp_ack);
  endtask

  // driver side: push expectation, clock the byte in, hand it to the monitor
  task automatic recv_byte(input byte unsigned exp, input bit host_ack, input string req);
    byte unsigned b;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(H);
      scl = 1'b1; hold(H / 2);
      b[i] = sda_line;
      hold(H / 2);
      scl = 1'b0;
    end
    got_q.push_back(b);
    -> got_ev;
    sda_h = host_ack ? 1'b0 : 1'b1; hold(H);
    scl = 1'b1; hold(H);
    scl = 1'b0;
  endtask

  // monitor: compares produced bytes against the queued expectations
  initial begin
    forever begin
      @(got_ev);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        byte unsigned g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g == e, t, g, e);
      end
    end
  end

  // R10 bus-level watch: SDA drive must not move while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && sda_oe != oe_prev) r10_bad++;
    oe_prev <= sda_oe;
  end

  task automatic byte_write(input byte unsigned dev, input byte unsigned wa, input byte unsigned d, input string req);
    bus_start();
    send_byte(dev, 1'b1, req);
    send_byte(wa, 1'b1, req);
    send_byte(d, 1'b1, req);
    bus_stop();
  endtask

  initial begin
    hold(4);
    chk(sda_oe == 1'b0, "R11 reset release", sda_oe, 0);
    rst_n = 1'b1;
    hold(4);

    // R11: fresh array reads zero at address 0 (current-address read)
    bus_start();
    send_byte(8'hA9, 1'b1, "R2 read device ack");
    recv_byte(8'h00, 1'b0, "R11 reset contents");
    bus_stop();

    // R9/R4: plain byte writes; device 0xA8 matches pins A2=1 A1=0
    byte_write(8'hA8, 8'h12, 8'hA5, "R9 write 0x012");
    byte_write(8'hAA, 8'hFF, 8'h3C, "R3 write 0x1FF via bit1=A8");
    byte_write(8'hA8, 8'h00, 8'h5E, "R9 write 0x000");

    // R5/R6: dummy write to 0x012, read device byte with bit1=1 ignored
    bus_start();
    send_byte(8'hA8, 1'b1, "R5 dummy dev");
    send_byte(8'h12, 1'b1, "R4 word ack");
    bus_start();
    send_byte(8'hAB, 1'b1, "R6 read dev ack");
    recv_byte(8'hA5, 1'b1, "R6 random read 0x012");
    recv_byte(8'h00, 1'b0, "R7 sequential 0x013");
    bus_stop();

    // R7: read from top of array wraps to 0x000
    bus_start();
    send_byte(8'hAA, 1'b1, "R3 dummy dev A8=1");
    send_byte(8'hFF, 1'b1, "R4 word ack");
    bus_start();
    send_byte(8'hA9, 1'b1, "R6 read dev ack");
    recv_byte(8'h3C, 1'b1, "R7 read 0x1FF");
    recv_byte(8'h5E, 1'b1, "R7 wrap to 0x000");
    recv_byte(8'h00, 1'b0, "R7 then 0x001");
    // R8: after NACK the slave stays off the line
    recv_byte(8'hFF, 1'b1, "R8 released after NACK");
    bus_stop();

    // R2/R3: chip select mismatch and wrong code get no ACK
    bus_start();
    send_byte(8'hAC, 1'b0, "R3 chip select mismatch");
    bus_stop();
    bus_start();
    send_byte(8'hB8, 1'b0, "R2 wrong device code");
    bus_stop();

    // R9/R5: data byte then repeated Start discards it
    bus_start();
    send_byte(8'hA8, 1'b1, "R9 dev");
    send_byte(8'h12, 1'b1, "R9 word");
    send_byte(8'hFF, 1'b1, "R9 data ack");
    bus_start();
    send_byte(8'hA9, 1'b1, "R6 read dev ack");
    recv_byte(8'hA5, 1'b0, "R9 discarded write");
    bus_stop();

    // R9: second data byte is refused
    bus_start();
    send_byte(8'hA8, 1'b1, "R9 dev");
    send_byte(8'h41, 1'b1, "R9 word");
    send_byte(8'h11, 1'b1, "R9 data ack");
    send_byte(8'h22, 1'b0, "R9 no page write");
    bus_stop();

    // R9: write then current-address read shows the increment
    byte_write(8'hA8, 8'h40, 8'h99, "R9 write 0x040");
    bus_start();
    send_byte(8'hA9, 1'b1, "R6 read dev ack");
    recv_byte(8'h11, 1'b0, "R9 address advanced to 0x041");
    bus_stop();

    hold(4 * H);
    chk(r10_bad == 0, "R10 SDA moves with SCL low", r10_bad, 0);
    chk(exp_q.size() == 0, "R6 monitor drained", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1 bus sequence hung actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule